// File: doc/BRIEF.md
# Staircase Amplitude Quantizer

This block lowers the amplitude resolution of an unsigned 8-bit audio stream. Each accepted sample is divided by a step size that can change at run time. The remainder is dropped, and the whole quotient is multiplied back by the same step. The result is a staircase version of the input that keeps about the same level. The step does not have to be a power of two. A larger step gives fewer, wider levels. A step of one gives the input back unchanged.

A sample and its step are taken in together on a cycle where the strobe is high and no earlier sample is still being worked on. The division is a restoring divider that produces one quotient bit per clock. The multiplication is a shift-and-add multiplier that handles one multiplier bit per clock. Both are built in plain RTL. The latency is therefore fixed at 2·W+2 clock edges, which is 18 for 8-bit samples. The result appears on a registered output together with a one-clock valid pulse. It stays on the output until the next result.

Top module: `bitcrush_core`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0 and `out_sample` is 0.
- R2: For an accepted sample s with step d ≥ 1, the result is floor(s/d)·d. This means the result is at most s, s minus the result is less than d, and the result is a whole multiple of d.
- R3: A step of 1 returns the accepted sample unchanged.
- R4: A step of 0 on `in_divisor` is handled exactly as a step of 1.
- R5: `out_valid` is high for exactly one cycle. It rises on the 18th rising edge after the edge that accepted the sample (2·W+2 edges for width W). `out_sample` changes only on the edge that raises `out_valid` and holds its value at all other times.
- R6: A strobe that arrives while a sample is still in flight is ignored. Every accepted sample produces exactly one result, and an ignored strobe produces no result.
- R7: The sample and the step are captured on the accepting edge. Later changes to `in_sample` or `in_divisor` do not affect that result.
- R8: A new sample can be accepted on the rising edge right after the edge that raises `out_valid`. This gives one result every 2·W+3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that marks `in_sample`/`in_divisor` as valid |
| in_sample | input | 8 | Unsigned input sample |
| in_divisor | input | 8 | Quantization step; 0 is treated as 1 |
| out_valid | output | 1 | One-cycle pulse when a crushed sample is ready |
| out_sample | output | 8 | Registered crushed sample |

## Verification
The assertions check the following on every cycle:
- The arithmetic identity of each result against the pair captured at acceptance, including the step-of-one and step-of-zero cases.
- The single-cycle valid pulse.
- The exact 18-edge latency, measured with a counter.
- That the output holds between results.
- That no result appears without a pending sample.

Only the bench scenarios show the following:
- That strobes arriving mid-computation are dropped, rather than queued or allowed to corrupt the result.
- That changing the inputs after acceptance has no effect.
- That a back-to-back sample is taken on the first edge after a result.
- That a full sweep of every step value matches the reference model.

// File: rtl/crush_pkg.sv
package crush_pkg;

  typedef enum logic [1:0] {
    CR_IDLE     = 2'd0,
    CR_DIVIDE   = 2'd1,
    CR_MULTIPLY = 2'd2
  } crush_state_e;

  // Edges from the accepting edge to the edge that raises out_valid.
  function automatic int crush_latency(input int width);
    return 2 * width + 2;
  endfunction

endpackage

// File: rtl/crush_divider.sv
module crush_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  // One restoring step: bring down the next dividend bit and try a subtract.
  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = (shifted >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dvs_q  <= divisor;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? diff : shifted;
        quo_q <= {quo_q[W-2:0], fits};
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;
  assign done     = done_q;
endmodule

// File: rtl/crush_multiplier.sv
module crush_multiplier #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mul_a,
  input  logic [W-1:0]   mul_b,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int PW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [PW-1:0] acc_q;
  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc_q   <= '0;
        mcand_q <= {{W{1'b0}}, mul_a};
        mplr_q  <= mul_b;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (mplr_q[0]) begin
          acc_q <= acc_q + mcand_q;
        end
        mcand_q <= {mcand_q[PW-2:0], 1'b0};
        mplr_q  <= {1'b0, mplr_q[W-1:1]};
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
  assign done    = done_q;
endmodule

// File: rtl/bitcrush_core.sv
module bitcrush_core #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] in_divisor,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  import crush_pkg::*;

  localparam int PW = 2 * SAMPLE_W;

  crush_state_e        state_q;
  logic [SAMPLE_W-1:0] step_q;
  logic [SAMPLE_W-1:0] step_eff;
  logic                idle_w;
  logic                accept;
  logic                div_done;
  logic                mul_start;
  logic                mul_done;
  logic [SAMPLE_W-1:0] quotient;
  logic [PW-1:0]       product;
  logic                out_valid_q;
  logic [SAMPLE_W-1:0] out_sample_q;

  always_comb begin
    step_eff  = (in_divisor == '0) ? SAMPLE_W'(1) : in_divisor;
    idle_w    = (state_q == CR_IDLE);
    accept    = idle_w && in_valid;
    mul_start = (state_q == CR_DIVIDE) && div_done;
  end

  crush_divider #(.W(SAMPLE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dividend (in_sample),
    .divisor  (step_eff),
    .quotient (quotient),
    .done     (div_done)
  );

  crush_multiplier #(.W(SAMPLE_W)) u_mul (
    .clk     (clk),
    .rst     (rst),
    .start   (mul_start),
    .mul_a   (quotient),
    .mul_b   (step_q),
    .product (product),
    .done    (mul_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= CR_IDLE;
      step_q       <= '0;
      out_valid_q  <= 1'b0;
      out_sample_q <= '0;
    end else begin
      out_valid_q <= 1'b0;
      case (state_q)
        CR_IDLE: begin
          if (in_valid) begin
            step_q  <= step_eff;
            state_q <= CR_DIVIDE;
          end
        end
        CR_DIVIDE: begin
          if (div_done) begin
            state_q <= CR_MULTIPLY;
          end
        end
        CR_MULTIPLY: begin
          if (mul_done) begin
            out_sample_q <= product[SAMPLE_W-1:0];
            out_valid_q  <= 1'b1;
            state_q      <= CR_IDLE;
          end
        end
        default: state_q <= CR_IDLE;
      endcase
    end
  end

  assign out_valid  = out_valid_q;
  assign out_sample = out_sample_q;
endmodule

// File: rtl/bitcrush_core_checker.sv
module bitcrush_core_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_sample,
  input logic [W-1:0] in_divisor,
  input logic         idle,
  input logic         out_valid,
  input logic [W-1:0] out_sample
);
  localparam int LAT = crush_pkg::crush_latency(W);
  localparam logic [15:0] LAT_MARK = 16'(LAT + 1);

  logic [W-1:0] cap_s;
  logic [W-1:0] cap_d;
  logic         cap_zero;
  logic         pending;
  logic [15:0]  lat_cnt;
  logic         take;

  assign take = idle && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_s    <= '0;
      cap_d    <= W'(1);
      cap_zero <= 1'b0;
      pending  <= 1'b0;
      lat_cnt  <= '0;
    end else begin
      if (take) begin
        cap_s    <= in_sample;
        cap_d    <= (in_divisor == '0) ? W'(1) : in_divisor;
        cap_zero <= (in_divisor == '0);
        pending  <= 1'b1;
        lat_cnt  <= 16'd1;
      end else begin
        if (out_valid) pending <= 1'b0;
        if (lat_cnt != 16'd0 && lat_cnt != 16'hFFFF) lat_cnt <= lat_cnt + 16'd1;
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat_cnt == LAT_MARK));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample));

  a_r6_one_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pending);

  a_r2_not_above: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sample <= cap_s));

  a_r2_within_step: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((cap_s - out_sample) < cap_d));

  a_r2_multiple: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_sample % cap_d) == '0));

  a_r3_identity: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_d == W'(1)) |-> (out_sample == cap_s));

  a_r4_zero_as_one: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_zero) |-> (out_sample == cap_s));
endmodule

bind bitcrush_core bitcrush_core_checker #(.W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .in_divisor (in_divisor),
  .idle       (idle_w),
  .out_valid  (out_valid),
  .out_sample (out_sample)
);

// File: tb/sim_bitcrush_core.sv
`timescale 1ns/1ps
module sim_bitcrush_core;
  localparam int W   = 8;
  localparam int LAT = 2 * W + 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] in_sample;
  logic [W-1:0] in_divisor;
  logic         out_valid;
  logic [W-1:0] out_sample;

  always #5 clk = ~clk;

  bitcrush_core #(.SAMPLE_W(W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_divisor (in_divisor),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit prev_valid = 1'b0;

  logic [W-1:0] exp_q[$];
  int           due_q[$];
  string        tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Driver: presents one strobe and pushes the expected result.
  task automatic send(input logic [W-1:0] s, input logic [W-1:0] d,
                      input string tag, input bit scramble, input int gap);
    logic [W-1:0] eff;
    logic [W-1:0] ex;
    eff = (d == '0) ? W'(1) : d;
    ex  = W'((s / eff) * eff);
    @(negedge clk);
    in_sample  = s;
    in_divisor = d;
    in_valid   = 1'b1;
    exp_q.push_back(ex);
    due_q.push_back(cyc + 1 + LAT);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) begin
      in_sample  = ~s;
      in_divisor = d + W'(3);
    end
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: pops and compares each result as it appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        chk(!prev_valid, "R5 pulse width", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected result", int'(out_sample), -1);
        end else begin
          logic [W-1:0] ex;
          int           due;
          string        tg;
          ex  = exp_q.pop_front();
          due = due_q.pop_front();
          tg  = tag_q.pop_front();
          chk(out_sample == ex, {tg, " data"}, int'(out_sample), int'(ex));
          chk(cyc == due, "R5 latency", cyc, due);
        end
      end
      prev_valid = out_valid;
    end
  end

  initial begin
    #1000000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst        = 1'b1;
    in_valid   = 1'b0;
    in_sample  = '0;
    in_divisor = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_sample == '0, "R1 sample in reset", int'(out_sample), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_sample == '0, "R1 sample after reset", int'(out_sample), 0);

    // R2 directed staircase points
    send(8'd200, 8'd7,   "R2 200/7",   1'b0, LAT);
    send(8'd255, 8'd16,  "R2 255/16",  1'b0, LAT);
    send(8'd0,   8'd255, "R2 0/255",   1'b0, LAT);
    send(8'd254, 8'd255, "R2 254/255", 1'b0, LAT);
    send(8'd255, 8'd255, "R2 255/255", 1'b0, LAT);
    send(8'd13,  8'd200, "R2 13/200",  1'b0, LAT);
    // R3 identity, R4 zero step
    send(8'd100, 8'd1,   "R3 step one", 1'b0, LAT);
    send(8'd255, 8'd1,   "R3 step one max", 1'b0, LAT);
    send(8'd77,  8'd0,   "R4 step zero", 1'b0, LAT);
    send(8'd255, 8'd0,   "R4 step zero max", 1'b0, LAT);
    // R7 inputs change right after acceptance
    send(8'd181, 8'd10,  "R7 latched", 1'b1, LAT);
    send(8'd99,  8'd0,   "R7 latched zero", 1'b1, LAT);

    // R6 strobes while busy are dropped
    send(8'd150, 8'd10, "R6 in flight", 1'b0, 4);
    in_sample = 8'd9; in_divisor = 8'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    in_sample = 8'd250; in_divisor = 8'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(negedge clk);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    chk(out_sample == 8'd150, "R6 output held", int'(out_sample), 150);
    chk(out_valid == 1'b0, "R6 no extra valid", int'(out_valid), 0);

    // R8 back-to-back at minimum spacing
    send(8'd201, 8'd50, "R8 first",  1'b0, LAT - 1);
    send(8'd99,  8'd9,  "R8 second", 1'b0, LAT - 1);
    send(8'd64,  8'd64, "R8 third",  1'b0, LAT);

    // R2 sweep of every step value
    for (int d = 0; d < 256; d++) begin
      send(W'((d * 37 + 11) & 255), W'(d), "R2 sweep", 1'b1, LAT - 1);
      send(8'd255, W'(d), "R2 sweep max", 1'b0, LAT);
    end

    repeat (LAT + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule